// File: doc/BRIEF.md
# General-Purpose Pin Controller with Event Interrupt

The block controls 32 general-purpose pins through six word-wide registers on a plain request/response register bus. Software picks the direction of each pin, records an open-drain preference for it, drives output pins through the data register and reads input pins back through the same register. Input pins pass through a two-flop synchronizer. A change on an input pin is latched as an event. A per-pin control bit selects whether any change is latched or only a high-to-low change.

A single level interrupt is raised while any latched event is also enabled in the mask register. Software clears events by writing ones to the event register. Register bit b belongs to pin (31 − b), so pin 0 is the most significant bit of every register.

The bus has no back-pressure. A write takes effect at the clock edge that samples the request. A read returns its word, with `rsp_valid` high, one cycle after the request. Only requests with `req_full` high, meaning a whole 32-bit word, have any effect.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Full-width writes and reads reach six registers at these byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14. Direction, open-drain, mask and edge control read back exactly what was written. Read data appears with `rsp_valid` one cycle after the request.
- R2: A write with `req_full` low changes nothing. A read with `req_full` low returns zero.
- R3: A read of any other offset returns zero, and a write to any other offset changes no register.
- R4: Pin n maps to register bit 31−n. `pin_oe[n]` equals direction bit 31−n (1 = output). `pin_out[n]` takes data bit 31−n at a data write only when that pin is an output. Otherwise `pin_out` holds its value.
- R5: For an input pin, the data bit reads the pin level after the two-flop synchronizer. For an output pin, the data bit reads the last value driven, and changes on its `pin_in` are ignored: no data change and no event.
- R6: With edge-control bit 0, any change of a synchronized input level sets that pin's event bit.
- R7: With edge-control bit 1, only a 1-to-0 change sets the event bit, and a 0-to-1 change does not.
- R8: Writing the event register clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R9: If an event is set and the same bit is cleared in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some bit is set in both the event and the mask registers. It follows register writes and input events with no added delay.
- R11: After reset all six registers read zero, and `pin_oe`, `pin_out` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Bus request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full 32-bit access |
| req_addr | input | AW (8) | Byte offset |
| req_wdata | input | NPIN (32) | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | NPIN (32) | Read data |
| pin_in | input | NPIN (32) | Pin levels, index = pin number |
| pin_out | output | NPIN (32) | Driven pin values, index = pin number |
| pin_oe | output | NPIN (32) | Output enable per pin |
| irq | output | 1 | Level interrupt |

## Verification
Event capture is tried with rising and falling changes on an input pin under both edge-control settings. These cases separate any-edge capture from falling-only capture. A toggle on a pin set as output confirms that direction gates both sampling and events. Clear writes with mixed ones and zeros tell write-one-to-clear apart from plain overwrite. A clear timed into the same cycle as a new edge shows whether set takes priority. Asymmetric direction and data patterns reveal a reversed pin-to-bit mapping, and narrow or unmapped accesses show that such accesses do nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DIR = 8'h00;
  localparam logic [7:0] OFS_ODR = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;
  localparam logic [7:0] OFS_EVT = 8'h0C;
  localparam logic [7:0] OFS_MSK = 8'h10;
  localparam logic [7:0] OFS_CTL = 8'h14;

  typedef struct packed {
    logic dir;
    logic odr;
    logic dat;
    logic evt;
    logic msk;
    logic ctl;
  } sel_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          en,
  input  logic          wr,
  input  logic          full,
  input  logic [AW-1:0] addr,
  output sel_t          wr_hit,
  output sel_t          rd_hit,
  output logic          rd_en
);
  sel_t hit;

  always_comb begin
    hit.dir = (addr == AW'(OFS_DIR));
    hit.odr = (addr == AW'(OFS_ODR));
    hit.dat = (addr == AW'(OFS_DAT));
    hit.evt = (addr == AW'(OFS_EVT));
    hit.msk = (addr == AW'(OFS_MSK));
    hit.ctl = (addr == AW'(OFS_CTL));
  end

  assign wr_hit = (en && wr && full) ? hit : '0;
  assign rd_hit = (en && !wr && full) ? hit : '0;
  assign rd_en  = en && !wr;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_evt_capture.sv
module gpio_evt_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ctl,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] set_v;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic chg, fall;
    assign chg      = cur[b] ^ prev[b];
    assign fall     = prev[b] & ~cur[b];
    assign set_v[b] = ~dir[b] & (ctl[b] ? fall : chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr) | set_v;
  end

  // R8: a bit only falls when a one was written to it
  p_clear_only_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~evt_q) & ~$past(clr)) == '0));

  // R9: an edge seen in a cycle is held even under a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(set_v)) == $past(set_v)));

  // R5: no new event on a pin configured as output
  p_out_noevt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & $past(dir)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_en,
  input  logic            req_wr,
  input  logic            req_full,
  input  logic [AW-1:0]   req_addr,
  input  logic [NPIN-1:0] req_wdata,
  output logic            rsp_valid,
  output logic [NPIN-1:0] rsp_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int MSB = NPIN - 1;

  sel_t wr_hit, rd_hit;
  logic rd_en;

  logic [NPIN-1:0] dir_q, odr_q, msk_q, ctl_q, out_q;
  logic [NPIN-1:0] pin_rv, syn, syn_prev, evt_q, evt_clr, dat_v, rd_mux;

  gpio_bus_decode #(.AW(AW)) u_dec (
    .en(req_en), .wr(req_wr), .full(req_full), .addr(req_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .rd_en(rd_en)
  );

  // pin n <-> register bit MSB-n
  for (genvar n = 0; n < NPIN; n++) begin : g_map
    assign pin_rv[MSB-n] = pin_in[n];
    assign pin_out[n]    = out_q[MSB-n];
    assign pin_oe[n]     = dir_q[MSB-n];
  end

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_rv), .q(syn), .q_prev(syn_prev)
  );

  assign evt_clr = wr_hit.evt ? req_wdata : '0;

  gpio_evt_capture #(.W(NPIN)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur(syn), .prev(syn_prev),
    .dir(dir_q), .ctl(ctl_q), .clr(evt_clr), .evt_q(evt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_hit.dir) dir_q <= req_wdata;
      if (wr_hit.odr) odr_q <= req_wdata;
      if (wr_hit.msk) msk_q <= req_wdata;
      if (wr_hit.ctl) ctl_q <= req_wdata;
      if (wr_hit.dat) out_q <= (dir_q & req_wdata) | (~dir_q & out_q);
    end
  end

  assign dat_v = (dir_q & out_q) | (~dir_q & syn);

  always_comb begin
    rd_mux = '0;
    if (rd_hit.dir) rd_mux = dir_q;
    if (rd_hit.odr) rd_mux = odr_q;
    if (rd_hit.dat) rd_mux = dat_v;
    if (rd_hit.evt) rd_mux = evt_q;
    if (rd_hit.msk) rd_mux = msk_q;
    if (rd_hit.ctl) rd_mux = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end

  assign irq = |(evt_q & msk_q);

  // R4: pins hold unless a data write arrives
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_en && req_wr && req_full && req_addr == AW'(OFS_DAT)) |=> $stable(pin_out));

  // R2: a narrow read returns zero
  p_narrow_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_wr && !req_full) |=> (rsp_rdata == '0));

  // R1: every read gets its response one cycle later
  p_rsp_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_wr) |=> rsp_valid);

  // R3: a write to an unmapped offset leaves direction and mask unchanged
  p_unmapped_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_wr && req_addr > AW'(OFS_CTL)) |=> ($stable(dir_q) && $stable(msk_q)));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_en = 1'b0, req_wr = 1'b0, req_full = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
    .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, bit full = 1'b1);
    req_en = 1'b1; req_wr = 1'b1; req_full = full; req_addr = a; req_wdata = d;
    tick();
    req_en = 1'b0; req_wr = 1'b0; req_full = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, input bit full = 1'b1);
    req_en = 1'b1; req_wr = 1'b0; req_full = full; req_addr = a;
    tick();
    req_en = 1'b0; req_full = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R11 oe", pin_oe, 0); chk("R11 out", pin_out, 0); chk("R11 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 24; a += 4) begin rd(8'(a), v); chk("R11 reg", v, 0); end
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(8'h04, 32'h1234_5678); rd(8'h04, v); chk("R1 odr", v, 32'h1234_5678);
    wr(8'h14, 32'h00F0_0000); rd(8'h14, v); chk("R1 ctl", v, 32'h00F0_0000);
    wr(8'h10, 32'h0000_0000); rd(8'h10, v); chk("R1 msk", v, 0);
    wr(8'h14, 32'h0); 
  endtask

  task automatic t_output;
    logic [31:0] v;
    wr(8'h00, 32'hC000_0000); chk("R4 oe", pin_oe, 32'h0000_0003);
    rd(8'h00, v); chk("R1 dir", v, 32'hC000_0000);
    wr(8'h08, 32'hFFFF_FFFF); chk("R4 out", pin_out, 32'h0000_0003);
    rd(8'h08, v); chk("R5 dat", v, 32'hC000_0000);
    wr(8'h08, 32'h4000_0000); chk("R4 out2", pin_out, 32'h0000_0002);
    wr(8'h08, 32'hC000_0000);
  endtask

  task automatic t_narrow_unmapped;
    logic [31:0] v;
    wr(8'h00, 32'h0, 1'b0); rd(8'h00, v); chk("R2 narrow wr", v, 32'hC000_0000);
    rd(8'h00, v, 1'b0); chk("R2 narrow rd", v, 0);
    wr(8'h10, 32'h0000_0100);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R3 rd", v, 0);
    rd(8'h10, v); chk("R3 msk kept", v, 32'h0000_0100);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_input_any;
    logic [31:0] v;
    pin_in[4] = 1'b1; tick(4);
    rd(8'h08, v); chk("R5 in dat", v, 32'hC800_0000);
    rd(8'h0C, v); chk("R6 rise evt", v, 32'h0800_0000);
    chk("R10 masked", {31'b0, irq}, 0);
    wr(8'h10, 32'h0800_0000); chk("R10 irq", {31'b0, irq}, 1);
    wr(8'h0C, 32'hF7FF_FFFF); rd(8'h0C, v); chk("R8 zero kept", v, 32'h0800_0000);
    wr(8'h0C, 32'h0800_0000); rd(8'h0C, v); chk("R8 cleared", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_fall_only;
    logic [31:0] v;
    wr(8'h14, 32'h0800_0000);
    pin_in[4] = 1'b0; tick(4);
    rd(8'h0C, v); chk("R7 fall evt", v, 32'h0800_0000);
    wr(8'h0C, 32'h0800_0000);
    pin_in[4] = 1'b1; tick(4);
    rd(8'h0C, v); chk("R7 rise ignored", v, 0);
    chk("R7 irq", {31'b0, irq}, 0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_out_ignored;
    logic [31:0] v;
    pin_in[0] = 1'b0; tick(4);
    rd(8'h08, v); chk("R5 out dat", v, 32'hC800_0000);
    pin_in[0] = 1'b1; tick(4);
    rd(8'h0C, v); chk("R5 out noevt", v, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    pin_in[4] = 1'b0; tick(4);
    rd(8'h0C, v); chk("R6 fall evt", v, 32'h0800_0000);
    pin_in[4] = 1'b1;
    tick(2);
    wr(8'h0C, 32'h0800_0000);
    rd(8'h0C, v); chk("R9 set wins", v, 32'h0800_0000);
    chk("R10 irq set", {31'b0, irq}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick();
    t_reset();
    t_regmap();
    t_output();
    t_narrow_unmapped();
    t_input_any();
    t_fall_only();
    t_out_ignored();
    t_set_wins();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule